// File: doc/BRIEF.md
# MDIO Management Master Controller

This block issues Clause 22 management frames to external PHYs over a two-wire management bus: a clock pin (MDC) and a bidirectional data line. The bidirectional line is given as three plain pins: an output value, an output enable and a sampled input, which a pad cell outside the block joins into one open line with a pull-up. Software talks to the block through a small register bank on a single-cycle 32-bit bus. A write strobe stores a word in the register chosen by the byte offset. Reads return the register contents combinationally.

Software first stores the payload in the write-data register. It then writes a command word that carries the register number, the PHY address, the raw two-bit start-of-frame code, the raw two-bit opcode and a start bit. A sequencer then runs through these states: `ST_IDLE`, `ST_PREAMBLE`, `ST_HEADER`, `ST_TURN`, `ST_DATA`, `ST_FINISH`. The transitions are: IDLE to PREAMBLE on an accepted launch. PREAMBLE to HEADER after 32 bits. HEADER to TURN after 14 bits. TURN to DATA after 2 bits. DATA to FINISH after 16 bits. FINISH to IDLE unconditionally one cycle later. Each bit step inside PREAMBLE, HEADER, TURN and DATA happens on an MDC falling edge. The start bit reads back as 1 for as long as the sequencer is out of `ST_IDLE`. When a read frame ends, the sixteen sampled bits and a failure flag are posted to the read-data and status registers.

Top module: `mdio_master`

## Requirements
- R1: The register offsets are fixed: command at 0x00, PHY/register address storage at 0x04, write data at 0x08, read data at 0x0C, status at 0x10. The register at 0x04 and the write-data register read back exactly what was written. Writes to 0x0C and 0x10 change nothing. Unmapped offsets read 0.
- R2: The command word holds the register number in bits 4:0, the PHY address in bits 9:5, the opcode in bits 11:10 and the start-of-frame code in bits 13:12. Each frame puts on the line, MSB first: 32 ones, then bits 13:12, then 11:10, then 9:5, then 4:0, all driven by the block.
- R3: Writing the command with bit 14 set launches one frame. Bit 14 then reads 1 from the next cycle until the frame ends, and 0 afterwards. Writing the command with bit 14 clear stores bits 13:0 and launches nothing.
- R4: A command write that arrives while bit 14 reads 1 is ignored. The stored command bits stay as they were and no second frame is sent.
- R5: When the opcode is anything other than 10, the block drives the turnaround as 1 then 0. It then drives bits 15:0 of the write-data register, MSB first. Bits 31:16 of that register are not sent.
- R6: When the opcode is 10 (read), the block releases the line for both turnaround bits and all 16 data bits. The sixteen sampled bits land in bits 15:0 of the read-data register, MSB first. Bits 31:16 of that register read 0.
- R7: Status bit 1 is set after a read whose second turnaround sample was not 0, which means no PHY answered. It is cleared after a read whose second turnaround sample was 0. Frames that are not reads leave it unchanged.
- R8: MDC toggles every DIV_HALF system clocks, only while a frame runs, and stays low otherwise. The line drive changes only at MDC falling edges. Input bits are sampled at MDC rising edges.
- R9: After reset every register reads 0, MDC is low and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the management data line |
| mdio_oe | output | 1 | Drive enable for the management data line |
| mdio_i | input | 1 | Sampled management data line |

## Verification
The bench builds the block with DIV_HALF = 2, so one MDC period is four system clocks and one whole frame takes about 260 cycles. With this setting, many complete write and read frames fit into a short run: frames to a present PHY, frames to an absent PHY, a command that lands in the middle of a frame, and an opcode that is not a read. A bench PHY model at one address answers reads and stores writes. A scoreboard compares every captured frame bit and drive-enable bit with the expected pattern, and measures the MDC period at each rising edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_FINISH
    } mdio_state_e;

    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int BUS_W     = 32;

    localparam int OFS_CMD   = 'h00;
    localparam int OFS_ADDR  = 'h04;
    localparam int OFS_WDATA = 'h08;
    localparam int OFS_RDATA = 'h0C;
    localparam int OFS_STAT  = 'h10;

    localparam int START_BIT = 14;
    localparam int ERR_BIT   = 1;

    localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);

    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = en && (cnt == LAST);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R9 / R8: the clock parks low once the sequencer is idle
    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [HDR_BITS-1:0]  hdr_in,
    input  logic [DATA_BITS-1:0] wdata_in,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdc,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 done,
    output logic                 done_read,
    output logic                 ta_bad,
    output logic [DATA_BITS-1:0] rd_val,
    output logic                 mdio_o,
    output logic                 mdio_oe
);

    localparam int CW = $clog2(PRE_BITS);

    mdio_state_e          state, state_n;
    logic [CW-1:0]        cnt, cnt_n;
    logic [HDR_BITS-1:0]  hdr_sr;
    logic [DATA_BITS-1:0] wd_sr;
    logic [DATA_BITS-1:0] rd_sr;
    logic                 is_read;
    logic                 ta_seen;

    // next-state selection
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (launch) begin
                    state_n = ST_PREAMBLE;
                    cnt_n   = '0;
                end
            end
            ST_PREAMBLE: begin
                if (fall_tick) begin
                    if (cnt == CW'(PRE_BITS - 1)) begin
                        state_n = ST_HEADER;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            end
            ST_HEADER: begin
                if (fall_tick) begin
                    if (cnt == CW'(HDR_BITS - 1)) begin
                        state_n = ST_TURN;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            end
            ST_TURN: begin
                if (fall_tick) begin
                    if (cnt == CW'(TA_BITS - 1)) begin
                        state_n = ST_DATA;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            end
            ST_DATA: begin
                if (fall_tick) begin
                    if (cnt == CW'(DATA_BITS - 1)) begin
                        state_n = ST_FINISH;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            end
            ST_FINISH: begin
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // shift registers and samplers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_sr  <= '0;
            wd_sr   <= '0;
            rd_sr   <= '0;
            is_read <= 1'b0;
            ta_seen <= 1'b0;
        end else begin
            if (state == ST_IDLE && launch) begin
                hdr_sr  <= hdr_in;
                wd_sr   <= wdata_in;
                rd_sr   <= '0;
                is_read <= (hdr_in[11:10] == OP_READ);
                ta_seen <= 1'b0;
            end
            if (fall_tick && state == ST_HEADER)
                hdr_sr <= {hdr_sr[HDR_BITS-2:0], 1'b0};
            if (fall_tick && state == ST_DATA)
                wd_sr <= {wd_sr[DATA_BITS-2:0], 1'b0};
            if (rise_tick && state == ST_TURN && cnt == CW'(TA_BITS - 1))
                ta_seen <= mdio_i;
            if (rise_tick && state == ST_DATA)
                rd_sr <= {rd_sr[DATA_BITS-2:0], mdio_i};
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            ST_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HEADER: begin
                mdio_o  = hdr_sr[HDR_BITS-1];
                mdio_oe = 1'b1;
            end
            ST_TURN: begin
                mdio_o  = (cnt == '0);
                mdio_oe = !is_read;
            end
            ST_DATA: begin
                mdio_o  = wd_sr[DATA_BITS-1];
                mdio_oe = !is_read;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
    end

    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_FINISH);
    assign done_read = is_read;
    assign ta_bad    = ta_seen;
    assign rd_val    = rd_sr;

    // R8: the line drive holds still while MDC stays high
    p_stable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8: a frame closes with MDC low
    p_finish_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mdc);

    // R3: an accepted launch makes the engine busy on the next cycle
    p_busy_after_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !busy) |=> busy);

endmodule

// File: rtl/mdio_regbank.sv
module mdio_regbank
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic                 busy,
    input  logic                 done,
    input  logic                 done_read,
    input  logic                 ta_bad,
    input  logic [DATA_BITS-1:0] rd_val,
    output logic                 launch,
    output logic [HDR_BITS-1:0]  hdr_out,
    output logic [DATA_BITS-1:0] wdata_out
);

    logic [HDR_BITS-1:0]  cmd_q;
    logic [BUS_W-1:0]     addr_q;
    logic [BUS_W-1:0]     wdat_q;
    logic [DATA_BITS-1:0] rdat_q;
    logic                 err_q;
    logic                 wr_cmd;

    assign wr_cmd    = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
    assign launch    = wr_cmd && bus_wdata[START_BIT] && !busy;
    assign hdr_out   = bus_wdata[HDR_BITS-1:0];
    assign wdata_out = wdat_q[DATA_BITS-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_cmd && !busy)
                cmd_q <= bus_wdata[HDR_BITS-1:0];
            if (bus_we && bus_addr == ADDR_W'(OFS_ADDR))
                addr_q <= bus_wdata;
            if (bus_we && bus_addr == ADDR_W'(OFS_WDATA))
                wdat_q <= bus_wdata;
            if (done && done_read) begin
                rdat_q <= rd_val;
                err_q  <= ta_bad;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CMD))
            bus_rdata = {{(BUS_W-START_BIT-1){1'b0}}, busy, cmd_q};
        else if (bus_addr == ADDR_W'(OFS_ADDR))
            bus_rdata = addr_q;
        else if (bus_addr == ADDR_W'(OFS_WDATA))
            bus_rdata = wdat_q;
        else if (bus_addr == ADDR_W'(OFS_RDATA))
            bus_rdata = {{(BUS_W-DATA_BITS){1'b0}}, rdat_q};
        else if (bus_addr == ADDR_W'(OFS_STAT))
            bus_rdata = {{(BUS_W-ERR_BIT-1){1'b0}}, err_q, 1'b0};
    end

    // R4: a command write during a frame leaves the stored command alone
    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && busy) |=> $stable(cmd_q));

    // R7: the error flag only moves when a read frame finishes
    p_err_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != $past(err_q)) |-> $past(done && done_read));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DIV_HALF = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic                 busy, done, done_read, ta_bad, launch;
    logic                 rise_tick, fall_tick;
    logic [DATA_BITS-1:0] rd_val, wdata16;
    logic [HDR_BITS-1:0]  hdr;

    mdio_regbank #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .done_read (done_read),
        .ta_bad    (ta_bad),
        .rd_val    (rd_val),
        .launch    (launch),
        .hdr_out   (hdr),
        .wdata_out (wdata16)
    );

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .hdr_in    (hdr),
        .wdata_in  (wdata16),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .done_read (done_read),
        .ta_bad    (ta_bad),
        .rd_val    (rd_val),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;

    localparam int DIV_HALF = 2;
    localparam int PHY_AD   = 5;
    localparam realtime MDC_PER = 2.0 * DIV_HALF * 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    always #2 clk = !clk;

    mdio_master #(.ADDR_W(5), .DIV_HALF(DIV_HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bench PHY and line model
    logic        phy_drv = 1'b0;
    logic        phy_out = 1'b1;
    logic [15:0] phy_mem [32];
    logic        line;
    assign line   = phy_drv ? phy_out : (mdio_oe ? mdio_o : 1'b1);
    assign mdio_i = line;

    // scoreboard
    typedef struct {
        logic [63:0] bits;
        logic [63:0] mask;
        logic [63:0] oe;
    } frame_t;
    frame_t exp_q[$];

    int          bit_idx = 64;
    logic [63:0] cap_bits, cap_oe;
    realtime     last_rise;
    bit          period_bad;
    logic [13:0] cap_hdr;

    always @(posedge mdc) begin
        if (bit_idx < 64) begin
            if (bit_idx > 0 && ($realtime - last_rise) != MDC_PER) period_bad = 1;
            last_rise = $realtime;
            cap_bits[63 - bit_idx] = line;
            cap_oe[63 - bit_idx]   = mdio_oe;
            bit_idx++;
            if (bit_idx == 64) begin
                cap_hdr = cap_bits[31:18];
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected frame", cap_bits, 64'h0);
                end else begin
                    frame_t e;
                    e = exp_q.pop_front();
                    chk((cap_bits & e.mask) == (e.bits & e.mask), "R2/R5 frame bits", cap_bits & e.mask, e.bits & e.mask);
                    chk(cap_oe == e.oe, "R5/R6 drive enable", cap_oe, e.oe);
                    chk(!period_bad, "R8 mdc period", {63'b0, period_bad}, 64'h0);
                end
                if (cap_hdr[13:12] == 2'b01 && cap_hdr[11:10] == 2'b01 && cap_hdr[9:5] == 5'(PHY_AD))
                    phy_mem[cap_hdr[4:0]] = cap_bits[15:0];
            end
        end else begin
            chk(1'b0, "R4 stray mdc edge", 64'h1, 64'h0);
        end
    end

    always @(negedge mdc) begin
        if (phy_drv && mdio_oe) chk(1'b0, "R6 line contention", 64'h1, 64'h0);
        if (bit_idx == 47) begin
            cap_hdr = cap_bits[31:18];
            if (cap_hdr[13:12] == 2'b01 && cap_hdr[11:10] == 2'b10 && cap_hdr[9:5] == 5'(PHY_AD)) begin
                phy_drv = 1'b1;
                phy_out = 1'b0;
            end
        end else if (bit_idx >= 48 && bit_idx < 64 && phy_drv) begin
            phy_out = phy_mem[cap_hdr[4:0]][63 - bit_idx];
        end else if (bit_idx >= 64) begin
            phy_drv = 1'b0;
            phy_out = 1'b1;
        end
    end

    // bus tasks
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            bus_read(5'h00, v);
            if (!v[14]) break;
        end
    endtask

    function automatic logic [13:0] fields(input logic [1:0] op, input int phy, input int rg);
        return {2'b01, op, 5'(phy), 5'(rg)};
    endfunction

    task automatic issue(input logic [13:0] f, input logic [15:0] wd);
        frame_t e;
        logic rd;
        rd = (f[11:10] == 2'b10);
        e.bits = {32'hFFFF_FFFF, f, 2'b10, wd};
        e.mask = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        e.oe   = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        exp_q.push_back(e);
        period_bad = 0;
        bit_idx = 0;
        bus_write(5'h00, {17'b0, 1'b1, f});
    endtask

    task automatic do_read(input int phy, input int rg, output logic [31:0] rd, output logic [31:0] st);
        issue(fields(2'b10, phy, rg), 16'h0);
        wait_idle();
        bus_read(5'h0C, rd);
        bus_read(5'h10, st);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            report();
        end
    end

    initial begin
        logic [31:0] v, s;
        logic [13:0] f;
        int idx_snap;
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'h1000 + 16'(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        bus_read(5'h00, v); chk(v == 0, "R9 cmd after reset", v, 0);
        bus_read(5'h04, v); chk(v == 0, "R9 addr after reset", v, 0);
        bus_read(5'h08, v); chk(v == 0, "R9 wdata after reset", v, 0);
        bus_read(5'h0C, v); chk(v == 0, "R9 rdata after reset", v, 0);
        bus_read(5'h10, v); chk(v == 0, "R9 status after reset", v, 0);
        chk(!mdc && !mdio_oe, "R9 pins after reset", {mdc, mdio_oe}, 0);

        // R1 register map
        bus_write(5'h04, 32'hCAFE_0123);
        bus_read(5'h04, v); chk(v == 32'hCAFE_0123, "R1 addr storage", v, 32'hCAFE_0123);
        bus_write(5'h0C, 32'hFFFF_FFFF);
        bus_read(5'h0C, v); chk(v == 0, "R1 rdata read-only", v, 0);
        bus_write(5'h10, 32'hFFFF_FFFF);
        bus_read(5'h10, v); chk(v == 0, "R1 status read-only", v, 0);
        bus_read(5'h18, v); chk(v == 0, "R1 unmapped", v, 0);

        // R5 write frame, R3 busy flag
        bus_write(5'h08, 32'hABCD_A5C3);
        bus_read(5'h08, v); chk(v == 32'hABCD_A5C3, "R1 wdata storage", v, 32'hABCD_A5C3);
        f = fields(2'b01, PHY_AD, 3);
        issue(f, 16'hA5C3);
        bus_read(5'h00, v); chk(v == {17'b0, 1'b1, f}, "R3 start reads 1 while running", v, {17'b0, 1'b1, f});
        wait_idle();
        bus_read(5'h00, v); chk(v == {18'b0, f}, "R3 start self-clears", v, {18'b0, f});
        bus_read(5'h10, v); chk(v == 0, "R7 write leaves status", v, 0);

        // R6 read from present PHY
        do_read(PHY_AD, 3, v, s);
        chk(v == 32'h0000_A5C3, "R6 read data", v, 32'h0000_A5C3);
        chk(s == 0, "R7 good read status", s, 0);

        // R7 absent PHY
        do_read(9, 1, v, s);
        chk(s == 32'h2, "R7 failed read flag", s, 32'h2);
        chk(v == 32'h0000_FFFF, "R6 pulled-up data", v, 32'h0000_FFFF);

        // R7 write frame keeps error
        bus_write(5'h08, 32'h0000_0F0F);
        issue(fields(2'b01, PHY_AD, 7), 16'h0F0F);
        wait_idle();
        bus_read(5'h10, v); chk(v == 32'h2, "R7 write keeps flag", v, 32'h2);
        do_read(PHY_AD, 7, v, s);
        chk(v == 32'h0000_0F0F, "R6 read back written reg", v, 32'h0000_0F0F);
        chk(s == 0, "R7 flag cleared by good read", s, 0);

        // R4 command during a frame is ignored
        f = fields(2'b10, PHY_AD, 4);
        issue(f, 16'h0);
        repeat (20) @(negedge clk);
        bus_write(5'h00, {17'b0, 1'b1, fields(2'b01, PHY_AD, 4)});
        bus_read(5'h00, v); chk(v == {17'b0, 1'b1, f}, "R4 stored command kept", v, {17'b0, 1'b1, f});
        wait_idle();
        repeat (300) @(negedge clk);
        chk(bit_idx == 64 && exp_q.size() == 0, "R4 no second frame", 64'(bit_idx), 64);
        bus_read(5'h0C, v); chk(v == 32'h0000_1004, "R4 phy reg untouched", v, 32'h0000_1004);

        // R3 start clear: store only
        idx_snap = bit_idx;
        f = fields(2'b01, 3, 6);
        bus_write(5'h00, {18'b0, f});
        repeat (100) @(negedge clk);
        bus_read(5'h00, v); chk(v == {18'b0, f}, "R3 store without launch", v, {18'b0, f});
        chk(!mdc && bit_idx == idx_snap, "R3 no frame without start", {mdc, 1'b0}, 0);

        // R5 opcode 11 treated as a write
        bus_write(5'h08, 32'h0000_3C5A);
        issue(fields(2'b11, PHY_AD, 8), 16'h3C5A);
        wait_idle();
        chk(!mdc && !mdio_oe, "R8 idle pins", {mdc, mdio_oe}, 0);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all frames seen", 64'(exp_q.size()), 0);

        report();
    end

endmodule